// File: doc/BRIEF.md
# Butterfly Merge Bit Transposer

This block converts packed 8-bit pixels into bitplane words for a planar display path. A group of 32 pixels arrives as eight 32-bit words, four pixels per word, over a valid/ready input. The block returns the same group as eight 32-bit words over a valid/ready output. Output word k is bitplane k, and it holds bit k of every pixel in the group.

Inside, the transpose runs through five fixed stages. Each stage exchanges masked bit fields between pairs of words, and the stages work at strides of 16, 8, 4, 2 and 1. A fixed word reordering sits where the group enters and where it leaves. Each stage is registered, so new groups keep arriving while older groups move down the pipe. With the output always ready, the block takes one group every eight cycles without a break. When the output stalls, the block holds its data in place.

Top module: `c2p_transposer`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `in_ready` are low. From the second clock edge after `rst_n` rises, an idle block shows `in_ready` high and `out_valid` low.
- R2: Input word w of a group (w = 0..7, in acceptance order) carries pixels 4w to 4w+3. Pixel 4w sits in bits 31:24 and pixel 4w+3 sits in bits 7:0. Every eighth accepted word closes a group.
- R3: Each group yields eight output words, plane 0 first and plane 7 last. Bit 31-p of plane k equals bit k of pixel p.
- R4: An all-zero group yields eight 0x00000000 words. A group of 0xFF pixels yields eight 0xFFFFFFFF words.
- R5: A group with a single set bit (bit b of pixel p) yields only one set output bit: bit 31-p of plane b.
- R6: While `out_ready` stays high, `in_ready` never drops. Back-to-back groups go in at one word per cycle, 32 words in 32 consecutive cycles.
- R7: If `out_valid` is high and `out_ready` is low at a clock edge, then in the next cycle `out_valid` is still high and `out_word` is unchanged.
- R8: Groups leave in the order they arrived. Each group yields exactly eight words, none lost and none added. At most 56 accepted words are held inside at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word is valid |
| in_word | input | 32 | Four packed pixels, first pixel in the top byte |
| in_ready | output | 1 | Block accepts an input word this cycle |
| out_valid | output | 1 | Output plane word is valid |
| out_word | output | 32 | Bitplane word, pixel 0 in bit 31 |
| out_ready | input | 1 | Sink accepts the output word this cycle |

## Verification
Two events can fall in the same cycle at each end of the block. At the input, the gatherer can hand a finished group to the first merge stage while it takes word 0 of the next group. At the output, the emitter can release plane 7 of one group while it loads the next group from the last stage. The bench provokes both by streaming groups back to back with the output always ready. It judges the result in two ways: `in_ready` never drops, so 32 words enter in 32 cycles, and every output word matches a nested-loop transpose. Random and held-low `out_ready` patterns then stall the handoff at the output, and those runs check that words are held and kept in order.

// File: rtl/c2p_pkg.sv
package c2p_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NWORDS  = 8;
  localparam int unsigned IDX_W   = $clog2(NWORDS);
  localparam int unsigned NSTAGES = 5;
  localparam int unsigned HELD_MAX = NWORDS * (NSTAGES + 2);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NWORDS-1:0][WORD_W-1:0] group_t;

  // exchange distance of merge stage s: 16, 8, 4, 2, 1
  function automatic int unsigned stage_shift(int unsigned s);
    return (WORD_W / 2) >> s;
  endfunction

  // lower half of every block of twice the shift
  function automatic word_t stage_mask(int unsigned s);
    word_t m;
    int sh;
    sh = int'(stage_shift(s));
    for (int i = 0; i < int'(WORD_W); i++) begin
      m[i] = (((i / sh) % 2) == 0);
    end
    return m;
  endfunction

  // word-index bit that separates the two words of a pair in stage s
  function automatic int unsigned stage_pair_bit(int unsigned s);
    case (s)
      0: return 2;
      1: return 1;
      2: return 0;
      3: return 2;
      default: return 1;
    endcase
  endfunction

  // pipeline word that holds plane k after the last stage
  function automatic int unsigned plane_src(int unsigned k);
    logic [2:0] b;
    b = k[2:0];
    return {29'd0, b[1], b[0], b[2]};
  endfunction

endpackage

// File: rtl/c2p_rst_sync.sv
module c2p_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/c2p_gather.sv
module c2p_gather
  import c2p_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  word_t  in_word,
  output logic   in_ready,
  output logic   grp_valid,
  output group_t grp_data,
  input  logic   grp_ready
);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;
  group_t           buf_q;
  logic             take, pass;
  logic [IDX_W-1:0] slot;

  assign pass     = full_q & grp_ready;
  assign in_ready = ~full_q | pass;
  assign take     = in_valid & in_ready;
  // word w is stored at slot NWORDS-1-w: complements the pixel index bits
  assign slot     = IDX_W'(NWORDS - 1) - cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (pass) full_d = 1'b0;
    if (take) begin
      if (cnt_q == IDX_W'(NWORDS - 1)) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) buf_q[slot] <= in_word;
  end

  assign grp_valid = full_q;
  assign grp_data  = buf_q;

endmodule

// File: rtl/c2p_merge_stage.sv
module c2p_merge_stage
  import c2p_pkg::*;
#(
  parameter int unsigned SHIFT    = 16,
  parameter word_t       MASK     = 32'h0000FFFF,
  parameter int unsigned PAIR_BIT = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  group_t in_data,
  output logic   up_ready,
  output logic   out_valid,
  output group_t out_data,
  input  logic   down_ready
);

  group_t merged;
  logic   vld_q, vld_d;
  logic   load;

  for (genvar i = 0; i < int'(NWORDS); i++) begin : g_word
    localparam int unsigned PARTNER = i ^ (1 << PAIR_BIT);
    word_t t;
    if (((i >> PAIR_BIT) & 1) == 0) begin : g_lo
      assign t         = ((in_data[i] >> SHIFT) ^ in_data[PARTNER]) & MASK;
      assign merged[i] = in_data[i] ^ (t << SHIFT);
    end else begin : g_hi
      assign t         = ((in_data[PARTNER] >> SHIFT) ^ in_data[i]) & MASK;
      assign merged[i] = in_data[i] ^ t;
    end
  end

  assign up_ready = ~vld_q | down_ready;
  assign load     = in_valid & up_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)            vld_d = 1'b1;
    else if (down_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= merged;
  end

  assign out_valid = vld_q;

endmodule

// File: rtl/c2p_emit.sv
module c2p_emit
  import c2p_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   grp_valid,
  input  group_t grp_data,
  output logic   grp_ready,
  output logic   out_valid,
  output word_t  out_word,
  input  logic   out_ready
);

  group_t           buf_q;
  group_t           perm;
  logic             loaded_q, loaded_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last, fire, load;

  for (genvar k = 0; k < int'(NWORDS); k++) begin : g_plane
    assign perm[k] = grp_data[plane_src(k)];
  end

  assign last      = (idx_q == IDX_W'(NWORDS - 1));
  assign fire      = loaded_q & out_ready;
  assign grp_ready = ~loaded_q | (out_ready & last);
  assign load      = grp_valid & grp_ready;

  always_comb begin
    loaded_d = loaded_q;
    idx_d    = idx_q;
    if (fire) begin
      if (last) loaded_d = 1'b0;
      else      idx_d    = idx_q + IDX_W'(1);
    end
    if (load) begin
      loaded_d = 1'b1;
      idx_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      loaded_q <= loaded_d;
      idx_q    <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) buf_q <= perm;
  end

  assign out_valid = loaded_q;
  assign out_word  = buf_q[idx_q];

endmodule

// File: rtl/c2p_transposer.sv
module c2p_transposer
  import c2p_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_word,
  input  logic        out_ready
);

  logic               srst_n;
  logic               gather_ready;
  logic [NSTAGES:0]   stg_valid;
  logic [NSTAGES:0]   stg_ready;
  group_t             stg_data [NSTAGES+1];

  c2p_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  c2p_gather u_gather (
    .clk       (clk),
    .rst_n     (srst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_ready  (gather_ready),
    .grp_valid (stg_valid[0]),
    .grp_data  (stg_data[0]),
    .grp_ready (stg_ready[0])
  );

  assign in_ready = srst_n & gather_ready;

  for (genvar s = 0; s < int'(NSTAGES); s++) begin : g_stage
    c2p_merge_stage #(
      .SHIFT    (stage_shift(s)),
      .MASK     (stage_mask(s)),
      .PAIR_BIT (stage_pair_bit(s))
    ) u_merge (
      .clk        (clk),
      .rst_n      (srst_n),
      .in_valid   (stg_valid[s]),
      .in_data    (stg_data[s]),
      .up_ready   (stg_ready[s]),
      .out_valid  (stg_valid[s+1]),
      .out_data   (stg_data[s+1]),
      .down_ready (stg_ready[s+1])
    );
  end

  c2p_emit u_emit (
    .clk       (clk),
    .rst_n     (srst_n),
    .grp_valid (stg_valid[NSTAGES]),
    .grp_data  (stg_data[NSTAGES]),
    .grp_ready (stg_ready[NSTAGES]),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_ready (out_ready)
  );

endmodule

// File: rtl/c2p_transposer_chk.sv
module c2p_transposer_chk
  import c2p_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word
);

  logic [6:0] held;
  logic [1:0] settle;
  logic       bp_seen;
  logic       in_fire, out_fire, bp_now;

  assign in_fire  = in_valid & in_ready;
  assign out_fire = out_valid & out_ready;
  assign bp_now   = out_valid & ~out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      settle  <= '0;
      bp_seen <= 1'b0;
    end else begin
      held    <= held + 7'(in_fire) - 7'(out_fire);
      if (settle != 2'd2) settle <= settle + 2'd1;
      bp_seen <= bp_seen | bp_now;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!out_valid && !in_ready)
        else $error("R1: handshake outputs active during reset");
    end
  end

  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  p_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 2'd2 && !bp_seen && !bp_now) |-> in_ready);

  p_held_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    held <= 7'(HELD_MAX));

  p_out_backed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (held != 7'd0));

endmodule

bind c2p_transposer c2p_transposer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word)
);

// File: tb/c2p_transposer_test.sv
module c2p_transposer_test;

  typedef logic [31:0][7:0]  pix_t;
  typedef logic [7:0][31:0]  planes_t;

  localparam int PERIOD = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_ready;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    stalls = 0;
  int    ready_mode = 0;
  string tag = "R3";
  logic [31:0] exp_q[$];

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  c2p_transposer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_ready (out_ready)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp,
                     input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic planes_t model(input pix_t px);
    planes_t r;
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 32; p++)
        r[k][31-p] = px[p][k];
    return r;
  endfunction

  // output monitor: sets out_ready, compares every accepted word, checks holds
  initial begin
    logic        stall_prev;
    logic [31:0] word_prev;
    stall_prev = 1'b0;
    word_prev  = '0;
    forever begin
      @(negedge clk);
      case (ready_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = (($urandom % 4) != 0);
        default: out_ready = 1'b0;
      endcase
      #1;
      if (stall_prev) begin
        chk("R7", {31'd0, out_valid}, 32'd1, "valid held");
        chk("R7", out_word, word_prev, "word held");
      end
      stall_prev = out_valid && !out_ready;
      word_prev  = out_word;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R8 extra word: got %h expected none", out_word);
        end else begin
          chk(tag, out_word, exp_q.pop_front(), "plane word");
        end
      end
    end
  end

  // entered and left at negedge+1
  task automatic put_word(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_group(input pix_t px);
    planes_t pl;
    pl = model(px);
    for (int k = 0; k < 8; k++) exp_q.push_back(pl[k]);
    for (int w = 0; w < 8; w++)
      put_word({px[4*w], px[4*w+1], px[4*w+2], px[4*w+3]});
  endtask

  task automatic wait_drain(input string req);
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 600) begin
      @(negedge clk); #1;
      n++;
    end
    chk(req, 32'(exp_q.size()), 32'd0, "words outstanding");
    repeat (3) @(negedge clk);
    #1;
    chk(req, {31'd0, out_valid}, 32'd0, "no extra word");
  endtask

  task automatic t_reset();
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_word   = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", {31'd0, out_valid}, 32'd0, "out_valid in reset");
    chk("R1", {31'd0, in_ready}, 32'd0, "in_ready in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", {31'd0, in_ready}, 32'd1, "in_ready after release");
    chk("R1", {31'd0, out_valid}, 32'd0, "out_valid after release");
  endtask

  task automatic t_flat();
    pix_t px;
    tag = "R4";
    px = '0;
    send_group(px);
    px = '1;
    send_group(px);
    wait_drain("R4");
  endtask

  task automatic t_single();
    pix_t px;
    int pp[5] = '{0, 31, 5, 18, 27};
    int bb[5] = '{0, 7, 3, 6, 1};
    tag = "R5";
    for (int i = 0; i < 5; i++) begin
      px = '0;
      px[pp[i]][bb[i]] = 1'b1;
      send_group(px);
    end
    wait_drain("R5");
  endtask

  task automatic t_packing();
    pix_t px;
    tag = "R2";
    for (int p = 0; p < 32; p++) px[p] = 8'(p);
    send_group(px);
    for (int p = 0; p < 32; p++) px[p] = 8'(8'hA5 ^ (p * 37));
    send_group(px);
    wait_drain("R2");
  endtask

  task automatic t_stream();
    pix_t px;
    int   t0;
    tag = "R6";
    ready_mode = 0;
    stalls = 0;
    t0 = cyc;
    for (int g = 0; g < 4; g++) begin
      for (int p = 0; p < 32; p++) px[p] = 8'($urandom);
      send_group(px);
    end
    chk("R6", 32'(stalls), 32'd0, "in_ready drops");
    chk("R6", 32'(cyc - t0), 32'd32, "cycles for 32 words");
    wait_drain("R6");
  endtask

  task automatic t_random();
    pix_t px;
    tag = "R3";
    ready_mode = 1;
    for (int g = 0; g < 6; g++) begin
      for (int p = 0; p < 32; p++) px[p] = 8'($urandom);
      send_group(px);
    end
    wait_drain("R3");
    ready_mode = 0;
  endtask

  task automatic t_hold();
    pix_t px;
    tag = "R8";
    ready_mode = 2;
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 32; p++) px[p] = 8'($urandom);
      send_group(px);
    end
    repeat (20) @(negedge clk);
    #1;
    chk("R7", {31'd0, out_valid}, 32'd1, "valid while stalled");
    chk("R8", 32'(exp_q.size()), 32'd16, "nothing released while stalled");
    ready_mode = 0;
    wait_drain("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_flat();
    t_single();
    t_packing();
    t_stream();
    t_random();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule